// File: doc/BRIEF.md
# Supervisory Reset Controller with Watchdog

This block is a synchronous supervisor for a processor. It drives one stretched reset from three sources. The first is a supply-low flag that an external comparator produces. The second is an active-low push-button input. The third is a watchdog that software must keep alive by toggling a strobe line. Every input first passes through a two-flop synchronizer. The push-button and supply-low inputs are then glitch-filtered by counting consecutive active samples. The reset is presented on a pair of outputs, one active-low and one active-high, which are always complements of each other.

The core is a three-state machine. In `ST_CAUSE` a level cause (filtered supply-low or filtered push-button) is present. In `ST_HOLD` the hold timer counts out a fixed stretch. In `ST_RUN` reset is released and the watchdog counts. The transitions are as follows:
- `ST_RUN -> ST_CAUSE` when a level cause appears.
- `ST_RUN -> ST_HOLD` on a watchdog expiry.
- `ST_CAUSE -> ST_HOLD` when every level cause has cleared.
- `ST_HOLD -> ST_CAUSE` when a level cause reappears. This restarts the stretch.
- `ST_HOLD -> ST_RUN` when the hold timer reaches its last count.

The block's own synchronous reset forces `ST_HOLD` with the timer at zero. The watchdog counter is held at zero in every state except `ST_RUN`. The watchdog is ignored entirely while the strobe pin is reported as floating.

Top module: `sup_reset_ctrl`

## Requirements
- R1: While `rst` is high, and for exactly `HOLD_CYC` clock edges after the first edge with `rst` low, `rst_o` is 1 (inputs idle: `pb_n_i`=1, `vlow_i`=0).
- R2: `rst_n_o` is the logical complement of `rst_o` in every cycle.
- R3: A low pulse on `pb_n_i` lasting fewer than `PB_GLITCH` clock cycles leaves `rst_o` at 0. A low pulse of `PB_GLITCH` cycles or more sets `rst_o` to 1.
- R4: A high pulse on `vlow_i` lasting fewer than `VLOW_GLITCH` cycles leaves `rst_o` at 0. A high pulse of `VLOW_GLITCH` cycles or more sets `rst_o` to 1.
- R5: After the last level cause is removed at an input pin, `rst_o` falls exactly `HOLD_CYC`+4 clock edges later. Of these, 2 edges are the synchronizer, 1 is the filter and 1 is the state machine.
- R6: With reset released, the strobe floating flag at 0 and no strobe transition, `rst_o` rises exactly `WD_CYC` edges after the release edge. It then stretches for the hold period.
- R7: Both a rising and a falling transition on `wdi_i` clear the watchdog. After the last transition is driven, expiry comes `WD_CYC`+3 edges later.
- R8: While `rst_o` is 1 the watchdog count stays at zero. Counting starts only after release, whatever the duration of the reset.
- R9: While `wdi_float_i` is 1, a watchdog timeout does not assert `rst_o`.
- R10: A level cause that arrives during the hold stretch restarts the stretch from zero once it clears again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous block reset (power-on), active high |
| vlow_i | input | 1 | Supply-below-threshold flag from an external comparator, active high, asynchronous |
| pb_n_i | input | 1 | Manual reset push-button, active low, asynchronous |
| wdi_i | input | 1 | Watchdog strobe; either transition services the watchdog |
| wdi_float_i | input | 1 | High when the strobe pin is undriven; disables watchdog resets |
| rst_n_o | output | 1 | Reset, active low |
| rst_o | output | 1 | Reset, active high |

## Verification
The bench measures the release delay exactly, edge by edge. A hold timer that is off by one, or a synchronizer stage that is missing, therefore shifts the count and is reported. Push-button and supply-low pulses are driven at one cycle below the filter length and at exactly the filter length. A filter that compares with the wrong bound would either pass the short glitch or swallow the legal pulse. The strobe is toggled at intervals of three quarters of the timeout. A watchdog that cleared only on rising edges would then expire while the strobe is being serviced. A long manual reset that outlasts several watchdog periods is followed by a full-timeout measurement, which exposes a watchdog that keeps counting under reset. A second cause injected mid-stretch exposes a hold timer that is not restarted.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_CAUSE = 2'd1,
        ST_HOLD  = 2'd2
    } sup_state_e;

endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            stab_q <= RST_VAL;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;

endmodule

// File: rtl/sup_glitch_filt.sv
module sup_glitch_filt #(
    parameter int LEN = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic act
);

    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(LEN - 1);

    logic [CW-1:0] run_cnt;
    logic          act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            act_q   <= 1'b0;
        end else if (!raw) begin
            run_cnt <= '0;
            act_q   <= 1'b0;
        end else if (run_cnt == CNT_LAST) begin
            act_q   <= 1'b1;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    assign act = act_q;

endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
    parameter int WD_CYC = 256,
    localparam int WW    = $clog2(WD_CYC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wdi_s,
    input  logic          float_s,
    input  logic          hold_clr,
    output logic          wdi_edge,
    output logic          expire,
    output logic [WW-1:0] wd_cnt
);

    localparam logic [WW-1:0] WD_LAST = WW'(WD_CYC - 1);

    logic          wdi_prev;
    logic [WW-1:0] cnt_q;
    logic          at_limit;

    assign wdi_edge = wdi_s ^ wdi_prev;
    assign at_limit = (cnt_q == WD_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            wdi_prev <= 1'b0;
            cnt_q    <= '0;
        end else begin
            wdi_prev <= wdi_s;
            if (hold_clr || wdi_edge || at_limit) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign expire = at_limit && !float_s && !hold_clr && !wdi_edge;
    assign wd_cnt = cnt_q;

endmodule

// File: rtl/sup_reset_ctrl.sv
module sup_reset_ctrl
    import sup_pkg::*;
#(
    parameter int HOLD_CYC    = 64,
    parameter int WD_CYC      = 256,
    parameter int PB_GLITCH   = 8,
    parameter int VLOW_GLITCH = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic vlow_i,
    input  logic pb_n_i,
    input  logic wdi_i,
    input  logic wdi_float_i,
    output logic rst_n_o,
    output logic rst_o
);

    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam int WW = $clog2(WD_CYC + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

    // synchronized inputs: {float, strobe, push-button (active low), supply-low}
    logic [3:0] sync_in;
    logic [3:0] sync_out;
    logic       vlow_s;
    logic       pb_n_s;
    logic       wdi_s;
    logic       float_s;

    assign sync_in = {wdi_float_i, wdi_i, pb_n_i, vlow_i};

    sup_sync2 #(
        .W       (4),
        .RST_VAL (4'b0010)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sync_in),
        .q   (sync_out)
    );

    assign vlow_s  = sync_out[0];
    assign pb_n_s  = sync_out[1];
    assign wdi_s   = sync_out[2];
    assign float_s = sync_out[3];

    logic pb_act;
    logic vlow_act;
    logic cause_lvl;

    sup_glitch_filt #(.LEN(PB_GLITCH)) u_pb_filt (
        .clk (clk),
        .rst (rst),
        .raw (!pb_n_s),
        .act (pb_act)
    );

    sup_glitch_filt #(.LEN(VLOW_GLITCH)) u_vlow_filt (
        .clk (clk),
        .rst (rst),
        .raw (vlow_s),
        .act (vlow_act)
    );

    assign cause_lvl = pb_act | vlow_act;

    sup_state_e    state_q;
    sup_state_e    state_d;
    logic [HW-1:0] hold_cnt;
    logic [HW-1:0] hold_cnt_d;
    logic          wd_expire;
    logic          wdi_edge;
    logic [WW-1:0] wd_cnt;
    logic          in_reset;

    sup_wdog #(.WD_CYC(WD_CYC)) u_wdog (
        .clk      (clk),
        .rst      (rst),
        .wdi_s    (wdi_s),
        .float_s  (float_s),
        .hold_clr (in_reset),
        .wdi_edge (wdi_edge),
        .expire   (wd_expire),
        .wd_cnt   (wd_cnt)
    );

    // next-state and hold-timer logic
    always_comb begin
        state_d    = state_q;
        hold_cnt_d = hold_cnt;
        unique case (state_q)
            ST_RUN: begin
                if (cause_lvl) begin
                    state_d    = ST_CAUSE;
                    hold_cnt_d = '0;
                end else if (wd_expire) begin
                    state_d    = ST_HOLD;
                    hold_cnt_d = '0;
                end
            end
            ST_CAUSE: begin
                hold_cnt_d = '0;
                if (!cause_lvl) begin
                    state_d = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (cause_lvl) begin
                    state_d    = ST_CAUSE;
                    hold_cnt_d = '0;
                end else if (hold_cnt == HOLD_LAST) begin
                    state_d    = ST_RUN;
                    hold_cnt_d = '0;
                end else begin
                    hold_cnt_d = hold_cnt + 1'b1;
                end
            end
            default: begin
                state_d    = ST_HOLD;
                hold_cnt_d = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_HOLD;
            hold_cnt <= '0;
        end else begin
            state_q  <= state_d;
            hold_cnt <= hold_cnt_d;
        end
    end

    // outputs
    always_comb begin
        in_reset = (state_q != ST_RUN);
        rst_o    = in_reset;
        rst_n_o  = !in_reset;
    end

endmodule

// File: rtl/sup_reset_chk.sv
module sup_reset_chk #(
    parameter int HOLD_CYC = 64,
    parameter int WD_CYC   = 256,
    localparam int HW      = $clog2(HOLD_CYC + 1),
    localparam int WW      = $clog2(WD_CYC + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          rst_o,
    input logic          rst_n_o,
    input logic          pb_act,
    input logic          vlow_act,
    input logic          float_s,
    input logic          wdi_edge,
    input logic [HW-1:0] hold_cnt,
    input logic [WW-1:0] wd_cnt
);

    // R2: outputs are complements
    p_compl_r2: assert property (@(posedge clk) disable iff (rst)
        rst_n_o == !rst_o);

    // R3: filtered push-button asserts reset on the next edge
    p_pb_assert_r3: assert property (@(posedge clk) disable iff (rst)
        pb_act |=> rst_o);

    // R4: filtered supply-low asserts reset on the next edge
    p_vlow_assert_r4: assert property (@(posedge clk) disable iff (rst)
        vlow_act |=> rst_o);

    // R5: reset is released only after the hold timer reached its last count
    p_hold_release_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_o) |-> ($past(hold_cnt) == HW'(HOLD_CYC - 1)));

    // R6: a timeout in run with no cause and no float asserts reset
    p_wd_expire_r6: assert property (@(posedge clk) disable iff (rst)
        (!rst_o && wd_cnt == WW'(WD_CYC - 1) && !float_s && !wdi_edge)
            |=> rst_o);

    // R7: a strobe transition clears the count
    p_wd_edge_r7: assert property (@(posedge clk) disable iff (rst)
        wdi_edge |=> (wd_cnt == '0));

    // R8: watchdog held at zero while reset is out
    p_wd_held_r8: assert property (@(posedge clk) disable iff (rst)
        rst_o |=> (wd_cnt == '0));

    // R9: with the strobe floating and no level cause, reset stays released
    p_float_r9: assert property (@(posedge clk) disable iff (rst)
        (!rst_o && float_s && !pb_act && !vlow_act) |=> !rst_o);

    // R10: a level cause during reset keeps the hold timer at zero
    p_restart_r10: assert property (@(posedge clk) disable iff (rst)
        (rst_o && (pb_act || vlow_act)) |=> (hold_cnt == '0));

    // watchdog count never passes its limit
    p_wd_range_r6: assert property (@(posedge clk) disable iff (rst)
        wd_cnt <= WW'(WD_CYC - 1));

endmodule

bind sup_reset_ctrl sup_reset_chk #(
    .HOLD_CYC (HOLD_CYC),
    .WD_CYC   (WD_CYC)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .rst_o    (rst_o),
    .rst_n_o  (rst_n_o),
    .pb_act   (pb_act),
    .vlow_act (vlow_act),
    .float_s  (float_s),
    .wdi_edge (wdi_edge),
    .hold_cnt (hold_cnt),
    .wd_cnt   (wd_cnt)
);

// File: tb/test_sup_reset_ctrl.sv
module test_sup_reset_ctrl;

    localparam int HOLD_CYC    = 64;
    localparam int WD_CYC      = 256;
    localparam int PB_GLITCH   = 8;
    localparam int VLOW_GLITCH = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vlow_i = 1'b0;
    logic pb_n_i = 1'b1;
    logic wdi_i = 1'b0;
    logic wdi_float_i = 1'b0;
    logic rst_n_o;
    logic rst_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sup_reset_ctrl #(
        .HOLD_CYC    (HOLD_CYC),
        .WD_CYC      (WD_CYC),
        .PB_GLITCH   (PB_GLITCH),
        .VLOW_GLITCH (VLOW_GLITCH)
    ) i_sup_reset_ctrl (
        .clk         (clk),
        .rst         (rst),
        .vlow_i      (vlow_i),
        .pb_n_i      (pb_n_i),
        .wdi_i       (wdi_i),
        .wdi_float_i (wdi_float_i),
        .rst_n_o     (rst_n_o),
        .rst_o       (rst_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R2: complement monitored on every sample
    int compl_bad = 0;
    always @(negedge clk) begin
        if (!rst && rst_n_o !== !rst_o) compl_bad++;
    end

    // count negedges until rst_o equals val (bounded)
    task automatic wait_rst(input logic val, input int limit, output int n);
        n = 0;
        while (rst_o !== val && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    // hold rst_o checked at 0 for n cycles; returns number of violations
    task automatic quiet(input int n, output int bad);
        bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_o !== 1'b0) bad++;
        end
    endtask

    task automatic t_power_on();
        int n;
        @(negedge clk);
        check(rst_o === 1'b1 && rst_n_o === 1'b0, "R1 reset state", rst_o, 1);
        rst = 1'b0;
        wait_rst(1'b0, HOLD_CYC + 50, n);
        check(n == HOLD_CYC, "R1 power-on hold", n, HOLD_CYC);
    endtask

    task automatic t_pb_glitch();
        int bad;
        int n;
        pb_n_i = 1'b0;
        repeat (PB_GLITCH - 1) @(negedge clk);
        pb_n_i = 1'b1;
        quiet(20, bad);
        check(bad == 0, "R3 short push-button ignored", bad, 0);
        pb_n_i = 1'b0;
        repeat (PB_GLITCH) @(negedge clk);
        pb_n_i = 1'b1;
        wait_rst(1'b1, 10, n);
        check(rst_o === 1'b1, "R3 push-button at filter length", rst_o, 1);
        wait_rst(1'b0, HOLD_CYC + 50, n);
        check(n == HOLD_CYC + 4 - 3, "R5 release after push-button", n, HOLD_CYC + 1);
    endtask

    task automatic t_pb_release();
        int n;
        pb_n_i = 1'b0;
        repeat (PB_GLITCH + 10) @(negedge clk);
        check(rst_o === 1'b1, "R3 push-button held", rst_o, 1);
        pb_n_i = 1'b1;
        wait_rst(1'b0, HOLD_CYC + 50, n);
        check(n == HOLD_CYC + 4, "R5 hold after push-button", n, HOLD_CYC + 4);
    endtask

    task automatic t_vlow();
        int bad;
        int n;
        vlow_i = 1'b1;
        repeat (VLOW_GLITCH - 1) @(negedge clk);
        vlow_i = 1'b0;
        quiet(20, bad);
        check(bad == 0, "R4 short supply dip ignored", bad, 0);
        vlow_i = 1'b1;
        repeat (VLOW_GLITCH + 10) @(negedge clk);
        check(rst_o === 1'b1, "R4 supply low asserts", rst_o, 1);
        vlow_i = 1'b0;
        wait_rst(1'b0, HOLD_CYC + 50, n);
        check(n == HOLD_CYC + 4, "R5 hold after supply low", n, HOLD_CYC + 4);
    endtask

    task automatic t_restart();
        int n;
        pb_n_i = 1'b0;
        repeat (PB_GLITCH + 4) @(negedge clk);
        pb_n_i = 1'b1;
        repeat (20) @(negedge clk);
        check(rst_o === 1'b1, "R10 in hold stretch", rst_o, 1);
        vlow_i = 1'b1;
        repeat (VLOW_GLITCH + 4) @(negedge clk);
        vlow_i = 1'b0;
        wait_rst(1'b0, HOLD_CYC + 50, n);
        check(n == HOLD_CYC + 4, "R10 stretch restarted", n, HOLD_CYC + 4);
    endtask

    task automatic t_wd_expire();
        int n;
        wait_rst(1'b1, WD_CYC + 50, n);
        check(n == WD_CYC, "R6 watchdog expiry", n, WD_CYC);
        wait_rst(1'b0, HOLD_CYC + 50, n);
        check(n == HOLD_CYC, "R6 hold after expiry", n, HOLD_CYC);
    endtask

    task automatic t_wd_held();
        int n;
        pb_n_i = 1'b0;
        repeat (3 * WD_CYC) @(negedge clk);
        check(rst_o === 1'b1, "R8 long push-button", rst_o, 1);
        pb_n_i = 1'b1;
        wait_rst(1'b0, HOLD_CYC + 50, n);
        check(n == HOLD_CYC + 4, "R8 release", n, HOLD_CYC + 4);
        wait_rst(1'b1, WD_CYC + 50, n);
        check(n == WD_CYC, "R8 full timeout after release", n, WD_CYC);
        wait_rst(1'b0, HOLD_CYC + 50, n);
    endtask

    task automatic t_wd_service();
        int bad;
        int tot = 0;
        int n;
        for (int k = 0; k < 6; k++) begin
            wdi_i = ~wdi_i;
            quiet((3 * WD_CYC) / 4, bad);
            tot += bad;
        end
        check(tot == 0, "R7 both strobe edges service", tot, 0);
        wdi_i = ~wdi_i;
        wait_rst(1'b1, WD_CYC + 50, n);
        check(n == WD_CYC + 3, "R7 expiry after last edge", n, WD_CYC + 3);
        wait_rst(1'b0, HOLD_CYC + 50, n);
    endtask

    task automatic t_float();
        int bad;
        int n;
        wdi_float_i = 1'b1;
        repeat (4) @(negedge clk);
        quiet(3 * WD_CYC, bad);
        check(bad == 0, "R9 floating strobe ignored", bad, 0);
        wdi_float_i = 1'b0;
        wait_rst(1'b1, WD_CYC + 50, n);
        check(rst_o === 1'b1, "R9 watchdog back after float clears", rst_o, 1);
        wait_rst(1'b0, HOLD_CYC + 50, n);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_power_on();
        t_pb_glitch();
        t_pb_release();
        t_vlow();
        t_restart();
        t_wd_expire();
        t_wd_held();
        t_wd_service();
        t_float();
        check(compl_bad == 0, "R2 complementary outputs", compl_bad, 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                check(1'b0, "watchdog timeout", 0, 1);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule